// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small two-way set-associative data cache. It sits between a processor-side request port and a main-memory port. The processor port carries one word at a time, with byte enables. The memory port always moves one whole line. Every way of every set keeps a line of data, its address tag, a valid flag and a dirty flag. Stores change only the cached copy and mark it dirty. Modified data reaches memory only when its line is replaced.

On a miss the controller picks a victim way. It takes an empty way if one exists; otherwise it takes the way the set's single recency bit names. A dirty victim is first written out to memory, and only then is the requested line fetched. After the fetch the request is looked up again, now hitting, and completes from the cache. A store miss therefore fetches the line first and merges the store into it. Addresses that match a parameterised non-cacheable window skip the arrays: they make one direct memory transaction and leave the cache contents untouched.

A request is held on the processor port until `cpu_ready` is high for one cycle. A cached hit completes in the cycle it is presented. The memory port holds a request until the memory returns a one-cycle acknowledge.

Top module: `wb_dcache`

## Requirements
- R1: After reset every way is invalid, `cpu_ready` and `mem_req` are low, and the first access to any cacheable address makes a memory line read.
- R2: A read hit returns the addressed word in the same cycle and makes no memory transaction.
- R3: A write hit updates only the bytes whose `cpu_be` bit is set, with bit i covering data bits 8i+7..8i, and makes no memory transaction. The modified line is later written back with the merged contents.
- R4: A read miss with an empty or clean victim makes exactly one memory read of the line that holds the address, and then returns the word from that line.
- R5: A write miss first reads the whole line from memory and then merges the write under the byte enables. The bytes that were not written keep the values from memory.
- R6: A way's recency state is updated on every hit and every fill. On a miss with both ways valid, the victim is the way that was used less recently.
- R7: A dirty victim is written to memory at its own line address, with all byte strobes set. The line read for the new address is issued only after that write is acknowledged.
- R8: A clean victim is replaced without any memory write.
- R9: A read whose address satisfies (`cpu_addr` & NC_MASK) == NC_MATCH goes to memory every time, returns the word from the returned line, and allocates no way. Lines already cached stay resident.
- R10: A write in the non-cacheable window makes one memory write. Its strobes cover only the bytes of the addressed word enabled by `cpu_be`: word w occupies line bytes 4w..4w+3.
- R11: `cpu_ready` stays low while a memory transaction is pending without acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Request present; held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory transaction requested |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 16 | Line-aligned byte address |
| mem_wdata | output | 128 | Line write data |
| mem_wstrb | output | 16 | Byte strobes for line writes |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid |
| mem_rdata | input | 128 | Line read data |

## Verification
The hardest case to reach is the two-transaction miss, where a dirty victim must be written back before the fill. It requires a set whose two ways both hold modified lines, with the recency bit pointing at a known one. The bench builds that state with one write hit and one write miss in the same set. It then reads the older way again to move the recency bit, and finally misses with a third tag. Its memory model logs the order, address and contents of every transaction, so the write-back address, the merged line data and the write-before-read order can all be checked.

// File: rtl/cache_pkg.sv
// Shared definitions for the write-back data cache.
// Assumes: associativity is fixed at two ways.
package cache_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2,
        ST_DIRECT = 2'd3
    } ctrl_state_t;
endpackage

// File: rtl/cache_tag_store.sv
// Tag, valid, dirty and recency state for all sets.
// Does: compares the request tag against both ways of one set and applies
// fill or hit updates. Assumes: at most one update per cycle.
module cache_tag_store
    import cache_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 9,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             rd_set,
    input  logic [TAG_W-1:0]             cmp_tag,
    output logic [WAYS-1:0]              hit_vec,
    output logic [WAYS-1:0]              valid_vec,
    output logic [WAYS-1:0]              dirty_vec,
    output logic                         lru_way,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    input  logic                         upd_fill,
    input  logic                         upd_hit,
    input  logic                         upd_way,
    input  logic                         upd_dirty
);
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0]            dirty_q [SETS];
    logic                       lru_q   [SETS];

    // Flag and recency state: cleared by reset, changed by fills and hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                lru_q[s]   <= 1'b0;
            end
        end else if (upd_fill) begin
            valid_q[rd_set][upd_way] <= 1'b1;
            dirty_q[rd_set][upd_way] <= 1'b0;
            lru_q[rd_set]            <= ~upd_way;
        end else if (upd_hit) begin
            lru_q[rd_set] <= ~upd_way;
            if (upd_dirty) begin
                dirty_q[rd_set][upd_way] <= 1'b1;
            end
        end
    end

    // Tag storage: written only when a line is filled.
    always_ff @(posedge clk) begin
        if (upd_fill) begin
            tag_q[rd_set][upd_way] <= cmp_tag;
        end
    end

    // Per-way compare of the request tag.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[rd_set][w] && (tag_q[rd_set][w] == cmp_tag);
    end

    assign valid_vec = valid_q[rd_set];
    assign dirty_vec = dirty_q[rd_set];
    assign lru_way   = lru_q[rd_set];
    assign rd_tag    = tag_q[rd_set];
endmodule

// File: rtl/cache_data_store.sv
// Line data storage with a byte-masked write port.
// Does: reads both ways of a set, writes selected bytes of one way.
// Assumes: data needs no reset; the valid flags guard its use.
module cache_data_store
    import cache_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int LINE_W = 128,
    localparam int IDX_W  = $clog2(SETS),
    localparam int LBYTES = LINE_W / 8
) (
    input  logic                          clk,
    input  logic [IDX_W-1:0]              set_idx,
    output logic [WAYS-1:0][LINE_W-1:0]   rd_line,
    input  logic                          wr_en,
    input  logic                          wr_way,
    input  logic [LBYTES-1:0]             wr_mask,
    input  logic [LINE_W-1:0]             wr_data
);
    logic [WAYS-1:0][LINE_W-1:0] line_q [SETS];

    // Byte-masked write into one way of the addressed set.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < LBYTES; b++) begin
                if (wr_mask[b]) begin
                    line_q[set_idx][wr_way][8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end
    end

    assign rd_line = line_q[set_idx];
endmodule

// File: rtl/cache_ctrl.sv
// Request sequencer for the cache.
// Does: serves hits at once, runs write-back then fill on a miss, and
// passes non-cacheable accesses straight to memory.
// Assumes: cpu request fields are held stable until cpu_ready.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 8,
    parameter logic [ADDR_W-1:0] NC_MASK  = '0,
    parameter logic [ADDR_W-1:0] NC_MATCH = '0,
    localparam int BPW    = DATA_W / 8,
    localparam int LINE_W = DATA_W * LINE_WORDS,
    localparam int LBYTES = LINE_W / 8,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(LINE_WORDS),
    localparam int OFF_W  = $clog2(LBYTES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_valid,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    input  logic [BPW-1:0]              cpu_be,
    output logic                        cpu_ready,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [LINE_W-1:0]           mem_wdata,
    output logic [LBYTES-1:0]           mem_wstrb,
    input  logic                        mem_ack,
    input  logic [LINE_W-1:0]           mem_rdata,
    output logic [IDX_W-1:0]            set_idx,
    output logic [TAG_W-1:0]            req_tag,
    input  logic [WAYS-1:0]             hit_vec,
    input  logic [WAYS-1:0]             valid_vec,
    input  logic [WAYS-1:0]             dirty_vec,
    input  logic                        lru_way,
    input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic                        upd_fill,
    output logic                        upd_hit,
    output logic                        upd_way,
    output logic                        upd_dirty,
    input  logic [WAYS-1:0][LINE_W-1:0] rd_line,
    output logic                        dw_en,
    output logic                        dw_way,
    output logic [LBYTES-1:0]           dw_mask,
    output logic [LINE_W-1:0]           dw_data
);
    ctrl_state_t state_q, state_d;
    logic        victim_q, victim_d;
    logic [WSEL_W-1:0] word_sel;
    logic        is_direct, is_hit, hit_way, pick_way;
    logic [LBYTES-1:0] word_mask;

    assign word_sel  = cpu_addr[OFF_W-1 -: WSEL_W];
    assign set_idx   = cpu_addr[OFF_W +: IDX_W];
    assign req_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign is_direct = (cpu_addr & NC_MASK) == NC_MATCH;
    assign is_hit    = |hit_vec;
    assign hit_way   = hit_vec[1];
    assign pick_way  = !valid_vec[0] ? 1'b0 : (!valid_vec[1] ? 1'b1 : lru_way);
    assign word_mask = LBYTES'(cpu_be) << (word_sel * BPW);

    // State and latched victim register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            victim_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            victim_q <= victim_d;
        end
    end

    // Next state, port outputs and array update strobes.
    always_comb begin
        state_d   = state_q;
        victim_d  = victim_q;
        cpu_ready = 1'b0;
        cpu_rdata = rd_line[hit_way][word_sel*DATA_W +: DATA_W];
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {req_tag, set_idx, {OFF_W{1'b0}}};
        mem_wdata = {LINE_WORDS{cpu_wdata}};
        mem_wstrb = '0;
        upd_fill  = 1'b0;
        upd_hit   = 1'b0;
        upd_way   = hit_way;
        upd_dirty = cpu_we;
        dw_en     = 1'b0;
        dw_way    = hit_way;
        dw_mask   = word_mask;
        dw_data   = {LINE_WORDS{cpu_wdata}};
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_valid) begin
                    if (is_direct) begin
                        state_d = ST_DIRECT;
                    end else if (is_hit) begin
                        cpu_ready = 1'b1;
                        upd_hit   = 1'b1;
                        dw_en     = cpu_we;
                    end else begin
                        victim_d = pick_way;
                        state_d  = (valid_vec[pick_way] && dirty_vec[pick_way])
                                   ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag[victim_q], set_idx, {OFF_W{1'b0}}};
                mem_wdata = rd_line[victim_q];
                mem_wstrb = '1;
                if (mem_ack) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    upd_fill = 1'b1;
                    upd_way  = victim_q;
                    dw_en    = 1'b1;
                    dw_way   = victim_q;
                    dw_mask  = '1;
                    dw_data  = mem_rdata;
                    state_d  = ST_IDLE;
                end
            end
            ST_DIRECT: begin
                mem_req   = 1'b1;
                mem_we    = cpu_we;
                mem_wstrb = cpu_we ? word_mask : '0;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    cpu_rdata = mem_rdata[word_sel*DATA_W +: DATA_W];
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/wb_dcache.sv
// Top of the two-way write-back data cache.
// Does: wires the sequencer to the tag and data stores.
// Assumes: memory acknowledges each line transaction with a one-cycle pulse.
module wb_dcache
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 8,
    parameter logic [ADDR_W-1:0] NC_MASK  = 16'hF000,
    parameter logic [ADDR_W-1:0] NC_MATCH = 16'hF000,
    localparam int BPW    = DATA_W / 8,
    localparam int LINE_W = DATA_W * LINE_WORDS,
    localparam int LBYTES = LINE_W / 8,
    localparam int IDX_W  = $clog2(SETS),
    localparam int OFF_W  = $clog2(LBYTES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BPW-1:0]    cpu_be,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    output logic [LBYTES-1:0] mem_wstrb,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    logic [IDX_W-1:0]            set_idx;
    logic [TAG_W-1:0]            req_tag;
    logic [WAYS-1:0]             hit_vec, valid_vec, dirty_vec;
    logic                        lru_way;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic                        upd_fill, upd_hit, upd_way, upd_dirty;
    logic [WAYS-1:0][LINE_W-1:0] rd_line;
    logic                        dw_en, dw_way;
    logic [LBYTES-1:0]           dw_mask;
    logic [LINE_W-1:0]           dw_data;

    cache_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS),
        .SETS(SETS), .NC_MASK(NC_MASK), .NC_MATCH(NC_MATCH)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .set_idx(set_idx), .req_tag(req_tag),
        .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
        .lru_way(lru_way), .rd_tag(rd_tag),
        .upd_fill(upd_fill), .upd_hit(upd_hit), .upd_way(upd_way),
        .upd_dirty(upd_dirty), .rd_line(rd_line),
        .dw_en(dw_en), .dw_way(dw_way), .dw_mask(dw_mask), .dw_data(dw_data)
    );

    cache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_set(set_idx), .cmp_tag(req_tag),
        .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
        .lru_way(lru_way), .rd_tag(rd_tag),
        .upd_fill(upd_fill), .upd_hit(upd_hit), .upd_way(upd_way),
        .upd_dirty(upd_dirty)
    );

    cache_data_store #(.SETS(SETS), .LINE_W(LINE_W)) u_data (
        .clk(clk), .set_idx(set_idx), .rd_line(rd_line),
        .wr_en(dw_en), .wr_way(dw_way), .wr_mask(dw_mask), .wr_data(dw_data)
    );
endmodule

// File: rtl/wb_dcache_chk.sv
// Port-level protocol checks for the write-back cache, bound to the top.
// Assumes: the same non-cacheable window parameters as the checked instance.
module wb_dcache_chk #(
    parameter int ADDR_W = 16,
    parameter int LBYTES = 16,
    parameter int BPW    = 4,
    parameter logic [ADDR_W-1:0] NC_MASK  = '0,
    parameter logic [ADDR_W-1:0] NC_MATCH = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LBYTES-1:0] mem_wstrb
);
    logic mem_direct;
    assign mem_direct = (mem_addr & NC_MASK) == NC_MATCH;

    // R11: no completion while memory is still outstanding
    p_stall_on_mem_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !(mem_req && !mem_ack));

    // R2: completion only for a presented request
    p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid);

    // R7: an unacknowledged memory request holds its address and direction
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R7: a write-back of a cached line uses every strobe
    p_evict_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_direct) |-> (&mem_wstrb));

    // R7: an acknowledged write-back is followed by the line read
    p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_we && !mem_direct) |=> (mem_req && !mem_we));

    // R10: a direct write touches at most one word of strobes
    p_direct_strb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_direct) |-> ($countones(mem_wstrb) <= BPW));
endmodule

bind wb_dcache wb_dcache_chk #(
    .ADDR_W(ADDR_W), .LBYTES(LBYTES), .BPW(BPW),
    .NC_MASK(NC_MASK), .NC_MATCH(NC_MATCH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wstrb(mem_wstrb)
);

// File: tb/wb_dcache_bench.sv
// Directed bench for wb_dcache: a line memory model with a transaction log
// and a golden word image kept from the requests alone.
module wb_dcache_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [3:0]   cpu_be = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         mem_req, mem_we;
    logic [15:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [15:0]  mem_wstrb;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;

    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0, seq = 0, rd_seq = 0, wr_seq = 0, stall_bad = 0;
    int dly = 0;
    logic [15:0]  last_wr_addr = '0, last_wr_strb = '0;
    logic [127:0] mem  [256];
    logic [127:0] gold [256];

    always #4 clk = ~clk;

    wb_dcache u_wb_dcache (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model: acknowledges after a short latency and logs each transaction.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (dly == 2) begin
                dly = 0;
                mem_ack <= 1'b1;
                seq = seq + 1;
                if (mem_we) begin
                    for (int b = 0; b < 16; b++)
                        if (mem_wstrb[b]) mem[mem_addr[11:4]][8*b +: 8] = mem_wdata[8*b +: 8];
                    wr_cnt = wr_cnt + 1; wr_seq = seq;
                    last_wr_addr = mem_addr; last_wr_strb = mem_wstrb;
                end else begin
                    mem_rdata <= mem[mem_addr[11:4]];
                    rd_cnt = rd_cnt + 1; rd_seq = seq;
                end
            end else begin
                dly = dly + 1;
            end
        end
    end

    // R11 monitor: completion while memory is outstanding.
    always @(negedge clk)
        if (rst_n && cpu_ready && mem_req && !mem_ack) stall_bad = stall_bad + 1;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d,
                          input logic [3:0] be, output logic [31:0] rd, output int waits);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        #1;
        waits = 0;
        while (!cpu_ready && waits < 1000) begin
            @(negedge clk); #1; waits++;
        end
        rd = cpu_rdata;
        if (we)
            for (int b = 0; b < 4; b++)
                if (be[b]) gold[a[11:4]][a[3:2]*32 + 8*b +: 8] = d[8*b +: 8];
        @(negedge clk);
        cpu_valid = 1'b0; cpu_we = 1'b0;
    endtask

    function automatic logic [31:0] gword(input logic [15:0] a);
        return gold[a[11:4]][a[3:2]*32 +: 32];
    endfunction

    task automatic t_reset_and_read_miss();
        logic [31:0] rd; int w, r0, w0;
        chk("R1 ready low after reset", cpu_ready, 0);
        chk("R1 no mem request after reset", mem_req, 0);
        r0 = rd_cnt; w0 = wr_cnt;
        access(0, 16'h0010, 0, 0, rd, w);
        chk("R1 first access reads line", rd_cnt - r0, 1);
        chk("R4 miss has no write", wr_cnt - w0, 0);
        chk("R4 miss data", rd, gword(16'h0010));
        chk("R11 miss stalls", (w >= 3), 1);
    endtask

    task automatic t_hits();
        logic [31:0] rd; int w, r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        access(0, 16'h0018, 0, 0, rd, w);
        chk("R2 hit data", rd, gword(16'h0018));
        chk("R2 hit zero wait", w, 0);
        access(1, 16'h0018, 32'h11223344, 4'b0101, rd, w);
        access(0, 16'h0018, 0, 0, rd, w);
        chk("R3 merged bytes", rd, gword(16'h0018));
        chk("R3 no memory traffic", (rd_cnt - r0) + (wr_cnt - w0), 0);
    endtask

    task automatic t_write_miss();
        logic [31:0] rd; int w, r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        access(1, 16'h0094, 32'hAABBCCDD, 4'b1010, rd, w);
        chk("R5 write miss fills once", rd_cnt - r0, 1);
        chk("R5 write miss no write", wr_cnt - w0, 0);
        access(0, 16'h0094, 0, 0, rd, w);
        chk("R5 merged word", rd, gword(16'h0094));
        access(0, 16'h0098, 0, 0, rd, w);
        chk("R5 rest of line from memory", rd, gword(16'h0098));
        chk("R5 reads after fill hit", rd_cnt - r0, 1);
    endtask

    task automatic t_evictions();
        logic [31:0] rd; int w, r0, w0;
        access(0, 16'h0010, 0, 0, rd, w);
        r0 = rd_cnt; w0 = wr_cnt;
        access(0, 16'h0110, 0, 0, rd, w);
        chk("R6 less recent way evicted", last_wr_addr, 16'h0090);
        chk("R7 written-back line", mem[8'h09], gold[8'h09]);
        chk("R7 write before read", (wr_seq < rd_seq), 1);
        chk("R7 one write one read", {wr_cnt - w0, rd_cnt - r0}, {32'd1, 32'd1});
        chk("R7 new line data", rd, gword(16'h0110));
        r0 = rd_cnt;
        access(0, 16'h0010, 0, 0, rd, w);
        chk("R6 recent way kept", rd_cnt - r0, 0);
        w0 = wr_cnt;
        access(0, 16'h0190, 0, 0, rd, w);
        chk("R8 clean victim no write", wr_cnt - w0, 0);
        access(0, 16'h0210, 0, 0, rd, w);
        chk("R3 dirty hit line written back", last_wr_addr, 16'h0010);
        chk("R3 merged line in memory", mem[8'h01], gold[8'h01]);
    endtask

    task automatic t_direct();
        logic [31:0] rd; int w, r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        access(0, 16'hF0F4, 0, 0, rd, w);
        access(0, 16'hF0F4, 0, 0, rd, w);
        chk("R9 each direct read goes to memory", rd_cnt - r0, 2);
        chk("R9 direct data", rd, gword(16'hF0F4));
        r0 = rd_cnt;
        access(0, 16'h0210, 0, 0, rd, w);
        chk("R9 cached line still resident", rd_cnt - r0, 0);
        access(1, 16'hF0F8, 32'h55667788, 4'b0011, rd, w);
        chk("R10 one direct write", wr_cnt - w0, 1);
        chk("R10 word strobes", last_wr_strb, 16'h0300);
        chk("R10 memory contents", mem[8'h0F], gold[8'h0F]);
        r0 = rd_cnt;
        access(0, 16'hF0F8, 0, 0, rd, w);
        chk("R9 direct read after write", rd, gword(16'hF0F8));
        chk("R9 no allocation on direct write", rd_cnt - r0, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++)
            for (int k = 0; k < 4; k++) begin
                mem[i][k*32 +: 32]  = 32'hC000_0000 | (i << 8) | k;
                gold[i][k*32 +: 32] = 32'hC000_0000 | (i << 8) | k;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset_and_read_miss();
        t_hits();
        t_write_miss();
        t_evictions();
        t_direct();
        chk("R11 no completion during memory wait", stall_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule